// File: doc/BRIEF.md
# Packed Mirrored Filter Coefficient Store

This block keeps the taps of a 32-tap linear-phase resampling filter in an eleven-word register file, three signed 9-bit taps per 27-bit word, and hands single taps to a filter datapath on request. The storage is folded. Taps 0 to 16 run upward from word 0. One pad slot follows. Taps 17 to 31 fill the remaining words, running downward and reversed inside each word. With this folding, a symmetric kernel stores its upper five words as a copy of its lower five words in reverse order.

Software or a sequencer loads only the half kernel. It pulses a start input and then presents six words under a valid qualifier. The block writes each word to its own slot and, in the same cycle, writes its mirror image into the upper half. A separate direct port can overwrite any single word when no load is running. The read port takes a tap number and returns that tap one cycle later, sign-extended to 16 bits. The filter arithmetic and phase stepping are left to the datapath that consumes the taps.

Top module: `coef_store`

## Requirements
- R1: A word holds three signed 9-bit taps: slot 0 at bits 8:0, slot 1 at bits 17:9 and slot 2 at bits 26:18. `rd_data_o` returns the tap selected by `rd_idx_i`, sign-extended to 16 bits, on the clock edge after the index is presented.
- R2: Tap t, for t from 0 to 16, is read from word t/3, slot t%3.
- R3: Tap t, for t from 17 to 31, is read from word 10 − (31−t)/3, slot (31−t)%3. The pad slot (word 5, bits 26:18) maps to no tap.
- R4: After a `load_start_i` pulse, the next six cycles with `load_valid_i` high store `load_word_i` into words 0 to 5 in order. Idle cycles are allowed between them. The word accepted as the i-th, for i from 0 to 4, is also stored into word 10−i on the same edge.
- R5: `load_done_o` is high for exactly one cycle. It rises on the edge that accepts the sixth load word.
- R6: When `wr_en_i` is high and no load is in progress, word `wr_addr_i` is replaced by `wr_word_i`. An address of 11 or above changes no word.
- R7: `wr_en_i` is ignored from the `load_start_i` cycle through the cycle that accepts the sixth load word. A direct write is accepted again once the load ends.
- R8: `load_valid_i` changes no word when no load is in progress.
- R9: Reset clears every word to zero and drives `rd_data_o` and `load_done_o` low.
- R10: After a half-kernel load in which word 5 carries c15 in slots 0 and 1, reading tap k returns the same value as reading tap 31−k, for every k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_start_i | input | 1 | Begins a half-kernel load |
| load_valid_i | input | 1 | Qualifies `load_word_i` during a load |
| load_word_i | input | 27 | Half-kernel word, three packed taps |
| load_done_o | output | 1 | One-cycle pulse when the load completes |
| wr_en_i | input | 1 | Direct word write strobe |
| wr_addr_i | input | 4 | Direct write word address |
| wr_word_i | input | 27 | Direct write data, three packed taps |
| rd_idx_i | input | 5 | Tap number to read |
| rd_data_o | output | 16 | Selected tap, sign-extended, one cycle latency |

## Verification
The assertions assume that a load follows protocol: a start pulse followed by valid words, with no second start before the sixth word arrives. Under that assumption the loader counter stays below six, and the primary and mirror write ports never target the same word. The bench drives each start only after the previous load has finished. It drives direct writes during a load only at addresses the loader has already written, so a wrongly accepted write would still be visible after the load. All inputs change on the falling edge, which keeps every value the properties sample settled.

// File: rtl/coef_store_pkg.sv
`timescale 1ns/1ps
package coef_store_pkg;

  localparam int unsigned COEF_W_D     = 9;
  localparam int unsigned SLOTS_D      = 3;
  localparam int unsigned HALF_WORDS_D = 6;
  localparam int unsigned OUT_W_D      = 16;

  typedef enum logic [0:0] {LD_IDLE = 1'b0, LD_RUN = 1'b1} ld_state_e;

  // taps stored ascending before the pad slot
  function automatic int unsigned asc_taps(int unsigned hw, int unsigned sl);
    return hw * sl - 1;
  endfunction

  function automatic int unsigned total_taps(int unsigned hw, int unsigned sl);
    return asc_taps(hw, sl) + (hw - 1) * sl;
  endfunction

  function automatic int unsigned tap_word(int unsigned t, int unsigned hw, int unsigned sl);
    if (t < asc_taps(hw, sl)) return t / sl;
    return (2 * hw - 2) - (total_taps(hw, sl) - 1 - t) / sl;
  endfunction

  function automatic int unsigned tap_slot(int unsigned t, int unsigned hw, int unsigned sl);
    if (t < asc_taps(hw, sl)) return t % sl;
    return (total_taps(hw, sl) - 1 - t) % sl;
  endfunction

endpackage

// File: rtl/coef_loader.sv
`timescale 1ns/1ps
module coef_loader
  import coef_store_pkg::*;
#(
  parameter int unsigned HALF_WORDS = HALF_WORDS_D,
  parameter int unsigned AW         = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          valid_i,
  output logic          busy_o,
  output logic          pri_en_o,
  output logic [AW-1:0] pri_addr_o,
  output logic          mir_en_o,
  output logic [AW-1:0] mir_addr_o,
  output logic          done_o
);

  localparam int unsigned WORDS = 2 * HALF_WORDS - 1;
  localparam int unsigned CW    = $clog2(HALF_WORDS);

  ld_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic            accept;
  logic            last;

  assign accept     = (state_q == LD_RUN) && valid_i && !start_i;
  assign last       = (cnt_q == CW'(HALF_WORDS - 1));
  assign busy_o     = start_i || (state_q == LD_RUN);
  assign pri_en_o   = accept;
  assign pri_addr_o = AW'(cnt_q);
  // final half word sits on the fold and has no mirror
  assign mir_en_o   = accept && !last;
  assign mir_addr_o = AW'(WORDS - 1) - AW'(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LD_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        state_q <= LD_RUN;
        cnt_q   <= '0;
      end else if (accept) begin
        if (last) begin
          state_q <= LD_IDLE;
          cnt_q   <= '0;
          done_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i));

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(HALF_WORDS));

endmodule

// File: rtl/coef_regfile.sv
`timescale 1ns/1ps
module coef_regfile #(
  parameter int unsigned WORD_W     = 27,
  parameter int unsigned HALF_WORDS = 6,
  parameter int unsigned AW         = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic [AW-1:0]     a_addr_i,
  input  logic [WORD_W-1:0] a_data_i,
  input  logic              b_en_i,
  input  logic [AW-1:0]     b_addr_i,
  input  logic [WORD_W-1:0] b_data_i,
  output logic [WORD_W-1:0] words_o [2*HALF_WORDS-1]
);

  localparam int unsigned WORDS = 2 * HALF_WORDS - 1;

  logic [WORD_W-1:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= '0;
      else if (a_en_i && a_addr_i == AW'(g))      mem_q[g] <= a_data_i;
      else if (b_en_i && b_addr_i == AW'(g))      mem_q[g] <= b_data_i;
    end
    assign words_o[g] = mem_q[g];
  end

  assert_port_clash_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && b_en_i) |-> (a_addr_i != b_addr_i));

  assert_mirror_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_en_i |-> (b_addr_i >= AW'(HALF_WORDS) && b_addr_i < AW'(WORDS)));

endmodule

// File: rtl/coef_reader.sv
`timescale 1ns/1ps
module coef_reader
  import coef_store_pkg::*;
#(
  parameter int unsigned COEF_W     = COEF_W_D,
  parameter int unsigned SLOTS      = SLOTS_D,
  parameter int unsigned HALF_WORDS = HALF_WORDS_D,
  parameter int unsigned OUT_W      = OUT_W_D,
  parameter int unsigned AW         = 4,
  parameter int unsigned TW         = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TW-1:0]           idx_i,
  input  logic [COEF_W*SLOTS-1:0] words_i [2*HALF_WORDS-1],
  output logic [OUT_W-1:0]        data_o
);

  localparam int unsigned WORD_W = COEF_W * SLOTS;

  logic [AW-1:0]     sel_word;
  int unsigned       sel_slot;
  logic [WORD_W-1:0] word_sel;
  logic [COEF_W-1:0] field;

  always_comb begin
    sel_word = AW'(tap_word(32'(idx_i), HALF_WORDS, SLOTS));
    sel_slot = tap_slot(32'(idx_i), HALF_WORDS, SLOTS);
    word_sel = words_i[sel_word];
    field    = COEF_W'(word_sel >> (sel_slot * COEF_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= {{(OUT_W - COEF_W){field[COEF_W-1]}}, field};
  end

  assert_sign_ext_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o[OUT_W-1:COEF_W] == {(OUT_W - COEF_W){data_o[COEF_W-1]}});

  assert_pad_unread_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_word == AW'(HALF_WORDS - 1) && sel_slot == SLOTS - 1));

endmodule

// File: rtl/coef_store.sv
`timescale 1ns/1ps
module coef_store
  import coef_store_pkg::*;
#(
  parameter int unsigned COEF_W     = COEF_W_D,
  parameter int unsigned SLOTS      = SLOTS_D,
  parameter int unsigned HALF_WORDS = HALF_WORDS_D,
  parameter int unsigned OUT_W      = OUT_W_D,
  localparam int unsigned WORD_W    = COEF_W * SLOTS,
  localparam int unsigned WORDS     = 2 * HALF_WORDS - 1,
  localparam int unsigned AW        = $clog2(WORDS),
  localparam int unsigned TAPS      = HALF_WORDS * SLOTS - 1 + (HALF_WORDS - 1) * SLOTS,
  localparam int unsigned TW        = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_start_i,
  input  logic              load_valid_i,
  input  logic [WORD_W-1:0] load_word_i,
  output logic              load_done_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [TW-1:0]     rd_idx_i,
  output logic [OUT_W-1:0]  rd_data_o
);

  logic              busy;
  logic              pri_en, mir_en;
  logic [AW-1:0]     pri_addr, mir_addr;
  logic              a_en;
  logic [AW-1:0]     a_addr;
  logic [WORD_W-1:0] a_data;
  logic [WORD_W-1:0] words [WORDS];

  coef_loader #(
    .HALF_WORDS(HALF_WORDS),
    .AW        (AW)
  ) u_loader (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (load_start_i),
    .valid_i   (load_valid_i),
    .busy_o    (busy),
    .pri_en_o  (pri_en),
    .pri_addr_o(pri_addr),
    .mir_en_o  (mir_en),
    .mir_addr_o(mir_addr),
    .done_o    (load_done_o)
  );

  // loader owns port A while busy; direct port otherwise
  always_comb begin
    if (busy) begin
      a_en   = pri_en;
      a_addr = pri_addr;
      a_data = load_word_i;
    end else begin
      a_en   = wr_en_i && (wr_addr_i < AW'(WORDS));
      a_addr = wr_addr_i;
      a_data = wr_word_i;
    end
  end

  coef_regfile #(
    .WORD_W    (WORD_W),
    .HALF_WORDS(HALF_WORDS),
    .AW        (AW)
  ) u_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .a_en_i  (a_en),
    .a_addr_i(a_addr),
    .a_data_i(a_data),
    .b_en_i  (mir_en),
    .b_addr_i(mir_addr),
    .b_data_i(load_word_i),
    .words_o (words)
  );

  coef_reader #(
    .COEF_W    (COEF_W),
    .SLOTS     (SLOTS),
    .HALF_WORDS(HALF_WORDS),
    .OUT_W     (OUT_W),
    .AW        (AW),
    .TW        (TW)
  ) u_reader (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (rd_idx_i),
    .words_i(words),
    .data_o (rd_data_o)
  );

  assert_mirror_with_primary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mir_en |-> (pri_en && load_valid_i));

  assert_no_direct_in_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_start_i && wr_en_i) |-> !(a_en && a_data == wr_word_i && a_data != load_word_i));

endmodule

// File: tb/sim_coef_store.sv
`timescale 1ns/1ps
module sim_coef_store;

  localparam int WORD_W = 27;
  localparam int AW     = 4;
  localparam int TW     = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_start = 1'b0, load_valid = 1'b0;
  logic [WORD_W-1:0] load_word = '0;
  logic              load_done;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [WORD_W-1:0] wr_word = '0;
  logic [TW-1:0]     rd_idx = '0;
  logic [15:0]       rd_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  coef_store u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .load_start_i(load_start),
    .load_valid_i(load_valid),
    .load_word_i (load_word),
    .load_done_o (load_done),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_word_i   (wr_word),
    .rd_idx_i    (rd_idx),
    .rd_data_o   (rd_data)
  );

  // half kernel c0..c15, symmetric filter
  localparam int KER [16] = '{-3, 0, 5, -9, 12, -20, 33, -47,
                               61, 80, -100, 120, -150, 200, -256, 255};

  function automatic logic [WORD_W-1:0] pack(int a, int b, int c);
    logic [8:0] fa, fb, fc;
    fa = a[8:0]; fb = b[8:0]; fc = c[8:0];
    return {fc, fb, fa};
  endfunction

  function automatic int kexp(int t);
    return (t < 16) ? KER[t] : KER[31 - t];
  endfunction

  function automatic logic [WORD_W-1:0] half_word(int i);
    if (i < 5) return pack(KER[3*i], KER[3*i+1], KER[3*i+2]);
    return pack(KER[15], KER[15], 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_tap(int t, output int v);
    @(negedge clk) rd_idx = TW'(t);
    @(negedge clk) v = int'($signed(rd_data));
  endtask

  task automatic direct_write(int a, logic [WORD_W-1:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_word = w;
    @(negedge clk) wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, w;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 rd_data in reset", int'(rd_data), 0);
    chk("R9 done in reset", int'(load_done), 0);
    rst_n = 1'b1;
    read_tap(0, v);  chk("R9 tap0 after reset", v, 0);
    read_tap(31, v); chk("R9 tap31 after reset", v, 0);

    // R8 valid without load
    @(negedge clk) begin load_valid = 1'b1; load_word = pack(1, 2, 3); end
    @(negedge clk) load_valid = 1'b0;
    read_tap(0, v); chk("R8 stray valid tap0", v, 0);
    read_tap(1, v); chk("R8 stray valid tap1", v, 0);

    // R6 direct writes, R2/R3 mapping, R1 sign extension
    direct_write(3, pack(5, -128, -256));
    read_tap(9, v);  chk("R2 tap9 word3 slot0", v, 5);
    read_tap(10, v); chk("R1 tap10 negative", v, -128);
    read_tap(11, v); chk("R1 tap11 min value", v, -256);
    direct_write(8, pack(7, -1, 100));
    read_tap(25, v); chk("R3 tap25 word8 slot0", v, 7);
    read_tap(24, v); chk("R3 tap24 word8 slot1", v, -1);
    read_tap(23, v); chk("R3 tap23 word8 slot2", v, 100);
    direct_write(12, pack(9, 9, 9));
    read_tap(0, v); chk("R6 out of range addr tap0", v, 0);
    read_tap(9, v); chk("R6 out of range addr tap9", v, 5);

    // R1 latency: value changes only after the edge
    @(negedge clk) rd_idx = TW'(10);
    #1 chk("R1 before edge", int'($signed(rd_data)), 5);
    @(negedge clk) chk("R1 after one edge", int'($signed(rd_data)), -128);

    // R4/R5/R7 half-kernel load with a gap and blocked direct writes
    @(negedge clk) load_start = 1'b1;
    @(negedge clk) load_start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i == 3) begin
        load_valid = 1'b0;
        wr_en = 1'b1; wr_addr = AW'(10); wr_word = pack(77, 77, 77);
        @(negedge clk) wr_en = 1'b0;
        chk("R5 done low in gap", int'(load_done), 0);
      end
      load_valid = 1'b1;
      load_word  = half_word(i);
      if (i == 5) begin
        wr_en = 1'b1; wr_addr = AW'(1); wr_word = pack(66, 66, 66);
      end
      @(negedge clk);
      wr_en = 1'b0;
      if (i < 5) chk("R5 done low mid load", int'(load_done), 0);
    end
    load_valid = 1'b0;
    chk("R5 done after sixth word", int'(load_done), 1);
    @(negedge clk) chk("R5 done single pulse", int'(load_done), 0);

    for (int t = 0; t < 32; t++) begin
      read_tap(t, v);
      chk($sformatf("R4 tap%0d after load", t), v, kexp(t));
    end
    read_tap(31, v); chk("R7 write in gap ignored tap31", v, KER[0]);
    read_tap(4, v);  chk("R7 write on last word ignored tap4", v, KER[4]);

    // R10 symmetry
    for (int k = 0; k < 16; k++) begin
      read_tap(k, v);
      read_tap(31 - k, w);
      chk($sformatf("R10 tap%0d vs tap%0d", k, 31 - k), v, w);
    end

    // R7 direct port usable again after load
    direct_write(0, pack(1, 2, 3));
    read_tap(1, v); chk("R7 direct write after load", v, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule